// File: doc/BRIEF.md
# Segmented Multi-Lane Sparse Row Dot-Product Unit

This block computes the row-by-row inner products of one loaded section of a column-blocked sparse matrix against a dense vector section. The section arrives as up to S non-zero values. Each value comes with a column position inside the block and a one-bit row-end marker. The unit walks the section in groups of P lanes per cycle. Each lane uses its column position to pick an element from the dense section, and the unit multiplies the pairs. It then sums the products that belong to the same row, using the row-end markers to split each lane group into segments.

A row can run past the last lane of a group. In that case its partial sum is carried into the next group's accumulation. When a row closes, the old partial result for that row is added to the new sum and the total is written back. Completed rows fill consecutive result entries 0, 1, 2 and so on, so each cycle writes between zero and P entries.

The work runs as a three-stage pipeline: gather and multiply, then segmented accumulation, then final merge and write-back. A start pulse captures the element count and the initial result contents. A done pulse reports that every row has been written and the pipeline is empty.

Top module: `mipa_unit`

## Requirements
- R1: After reset, busy_o and done_o are low and every result entry in res_o is zero.
- R2: A start_i seen while busy_o is low captures cnt_i and loads all S entries of cinit_i into the result storage, and busy_o is high in the next cycle. A start_i seen while busy_o is high has no effect on the results or the timing.
- R3: Element i (for i below the count) contributes val[i] times vec[pos[i]]. Both are 16-bit two's complement, entry i occupies bits [16*i+15:16*i] of its bus, and pos[i] is a 3-bit index at bits [3*i+2:3*i]. Products and sums are sign-extended to 40 bits and wrap modulo 2^40.
- R4: A row ends at each element whose bit i in eor_i is 1. The k-th row to end, counting from 0, adds its sum to result entry k, which occupies bits [40*k+39:40*k] of res_o and cinit_i.
- R5: A row whose elements span several lane groups is summed as one row, with the partial sum carried across groups.
- R6: Element count-1 always ends its row, whether or not its eor_i bit is set.
- R7: Elements at index count or above, and their eor_i bits, have no effect. Result entries at or above the number of completed rows keep their cinit_i value.
- R8: done_o is a single-cycle pulse with busy_o low. For a count n of 1 or more, done_o rises ceil(n/P)+3 clock edges after the edge that accepted start_i.
- R9: With a count of zero, no entry changes, and done_o rises one edge after the accepted start.
- R10: While busy_o is low and no start_i is given, res_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation |
| cnt_i | input | 4 | Number of valid elements (0 to S) |
| val_i | input | S*16 | Non-zero values, held while busy |
| pos_i | input | S*3 | Column position of each value within the block |
| eor_i | input | S | Row-end marker per element |
| vec_i | input | S*16 | Dense vector section |
| cinit_i | input | S*40 | Initial partial results, captured at start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | S*40 | Result entries |

## Verification
Every row-end marker pattern is applied for every count from 1 to 8 with random values and positions. This covers one row per lane, with up to P writes in a cycle, as well as single rows that cross one or more group boundaries. Directed sections set markers beyond the count, which shows whether unused lanes are masked. A section with no marker on its final element tests the forced row close. Extreme negative values and a near-full initial entry separate correct sign extension from wrong sign extension and correct 40-bit wrap from saturation. A repeated start during an operation, sent with different initial contents, shows whether a busy start is truly ignored.

// File: rtl/mipa_pkg.sv
package mipa_pkg;
   // minimum bit count that indexes n items (at least one bit)
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/mipa_gather_mul.sv
module mipa_gather_mul
   import mipa_pkg::*;
#(
   parameter int unsigned S  = 8,
   parameter int unsigned P  = 4,
   parameter int unsigned VW = 16,
   parameter int unsigned AW = 40,
   parameter int unsigned PW = idx_bits(S),
   parameter int unsigned CW = idx_bits(S + 1),
   parameter int unsigned IW = CW + idx_bits(P) + 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            issue,
   input  logic [IW-1:0]   base,
   input  logic [CW-1:0]   cnt,
   input  logic [S*VW-1:0] vals,
   input  logic [S*PW-1:0] poss,
   input  logic [S-1:0]    eors,
   input  logic [S*VW-1:0] vec,
   output logic [P*AW-1:0] prod_q,
   output logic [P-1:0]    live_q,
   output logic [P-1:0]    last_q
);
   localparam int unsigned SW = idx_bits(S);

   logic [IW-1:0] cnt_x;
   assign cnt_x = {{(IW-CW){1'b0}}, cnt};

   for (genvar k = 0; k < P; k++) begin : g_lane
      logic [IW-1:0]          idx;
      logic                   ok;
      logic [SW-1:0]          sel;
      logic [PW-1:0]          col;
      logic signed [VW-1:0]   a_v;
      logic signed [VW-1:0]   b_v;
      logic signed [AW-1:0]   a_x;
      logic signed [AW-1:0]   b_x;
      logic signed [AW-1:0]   prod;
      logic                   fin;

      assign idx  = base + IW'(k);
      assign ok   = issue && (idx < cnt_x);
      assign sel  = ok ? idx[SW-1:0] : '0;
      assign col  = poss[sel*PW +: PW];
      assign a_v  = vals[sel*VW +: VW];
      assign b_v  = vec[col*VW +: VW];
      assign a_x  = AW'(a_v);
      assign b_x  = AW'(b_v);
      assign prod = a_x * b_x;
      assign fin  = ok && (eors[sel] || (idx == cnt_x - IW'(1)));

      always_ff @(posedge clk) begin
         if (rst) begin
            prod_q[k*AW +: AW] <= '0;
            live_q[k]          <= 1'b0;
            last_q[k]          <= 1'b0;
         end else begin
            prod_q[k*AW +: AW] <= ok ? prod : '0;
            live_q[k]          <= ok;
            last_q[k]          <= fin;
         end
      end
   end
endmodule

// File: rtl/mipa_seg_accum.sv
module mipa_seg_accum
   import mipa_pkg::*;
#(
   parameter int unsigned S  = 8,
   parameter int unsigned P  = 4,
   parameter int unsigned AW = 40,
   parameter int unsigned RW = idx_bits(S)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            clear,
   input  logic [P*AW-1:0] prod,
   input  logic [P-1:0]    live,
   input  logic [P-1:0]    last,
   output logic [P*AW-1:0] sum_q,
   output logic [P-1:0]    wr_q,
   output logic [P*RW-1:0] row_q
);
   localparam int unsigned RCW = idx_bits(S + 1);

   logic [AW-1:0]   carry_q;
   logic [RCW-1:0]  rowc_q;
   logic [AW-1:0]   run;
   logic [RCW-1:0]  nrow;
   logic [P*AW-1:0] seg_sum;
   logic [P*RW-1:0] seg_row;

   always_comb begin
      run     = carry_q;
      nrow    = rowc_q;
      seg_sum = '0;
      seg_row = '0;
      for (int k = 0; k < P; k++) begin
         if (live[k]) run = run + prod[k*AW +: AW];
         seg_sum[k*AW +: AW] = run;
         seg_row[k*RW +: RW] = nrow[RW-1:0];
         if (last[k]) begin
            run  = '0;
            nrow = nrow + RCW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         carry_q <= '0;
         rowc_q  <= '0;
         wr_q    <= '0;
         sum_q   <= '0;
         row_q   <= '0;
      end else begin
         carry_q <= run;
         rowc_q  <= nrow;
         wr_q    <= last;
         sum_q   <= seg_sum;
         row_q   <= seg_row;
      end
   end
endmodule

// File: rtl/mipa_writeback.sv
module mipa_writeback
   import mipa_pkg::*;
#(
   parameter int unsigned S  = 8,
   parameter int unsigned P  = 4,
   parameter int unsigned AW = 40,
   parameter int unsigned RW = idx_bits(S)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load,
   input  logic [S*AW-1:0] init,
   input  logic [P-1:0]    wr,
   input  logic [P*AW-1:0] sum,
   input  logic [P*RW-1:0] row,
   output logic [S*AW-1:0] res
);
   for (genvar j = 0; j < S; j++) begin : g_ent
      logic [AW-1:0] inc;
      always_comb begin
         inc = '0;
         for (int k = 0; k < P; k++) begin
            if (wr[k] && (row[k*RW +: RW] == RW'(j))) inc = sum[k*AW +: AW];
         end
      end
      always_ff @(posedge clk) begin
         if (rst)       res[j*AW +: AW] <= '0;
         else if (load) res[j*AW +: AW] <= init[j*AW +: AW];
         else           res[j*AW +: AW] <= res[j*AW +: AW] + inc;
      end
   end
endmodule

// File: rtl/mipa_unit.sv
module mipa_unit
   import mipa_pkg::*;
#(
   parameter int unsigned S  = 8,
   parameter int unsigned P  = 4,
   parameter int unsigned VW = 16,
   parameter int unsigned AW = 40,
   parameter int unsigned PW = idx_bits(S),
   parameter int unsigned CW = idx_bits(S + 1)
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            start_i,
   input  logic [CW-1:0]   cnt_i,
   input  logic [S*VW-1:0] val_i,
   input  logic [S*PW-1:0] pos_i,
   input  logic [S-1:0]    eor_i,
   input  logic [S*VW-1:0] vec_i,
   input  logic [S*AW-1:0] cinit_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [S*AW-1:0] res_o
);
   localparam int unsigned IW = CW + idx_bits(P) + 1;
   localparam int unsigned RW = idx_bits(S);

   if (P < 1 || S < P || AW < 2 * VW || PW < idx_bits(S)) begin : g_bad_cfg
      $error("mipa_unit: unsupported parameter combination");
   end

   logic            accept;
   logic [CW-1:0]   cnt_q;
   logic [IW-1:0]   base_q;
   logic            issuing;
   logic            s1v_q;
   logic            s2v_q;
   logic [P*AW-1:0] s1_prod;
   logic [P-1:0]    s1_live;
   logic [P-1:0]    s1_last;
   logic [P*AW-1:0] s2_sum;
   logic [P-1:0]    s2_wr;
   logic [P*RW-1:0] s2_row;

   assign accept  = start_i && !busy_o;
   assign issuing = busy_o && (base_q < {{(IW-CW){1'b0}}, cnt_q});

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         busy_o <= 1'b0;
         done_o <= 1'b0;
         cnt_q  <= '0;
         base_q <= '0;
         s1v_q  <= 1'b0;
         s2v_q  <= 1'b0;
      end else begin
         s1v_q  <= issuing;
         s2v_q  <= s1v_q;
         done_o <= 1'b0;
         if (accept) begin
            busy_o <= 1'b1;
            cnt_q  <= cnt_i;
            base_q <= '0;
         end else if (issuing) begin
            base_q <= base_q + IW'(P);
         end else if (busy_o && !s1v_q && !s2v_q) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
         end
      end
   end

   mipa_gather_mul #(.S(S), .P(P), .VW(VW), .AW(AW), .PW(PW), .CW(CW), .IW(IW)) u_s1 (
      .clk(clk_i), .rst(rst_i), .issue(issuing), .base(base_q), .cnt(cnt_q),
      .vals(val_i), .poss(pos_i), .eors(eor_i), .vec(vec_i),
      .prod_q(s1_prod), .live_q(s1_live), .last_q(s1_last)
   );

   mipa_seg_accum #(.S(S), .P(P), .AW(AW), .RW(RW)) u_s2 (
      .clk(clk_i), .rst(rst_i), .clear(accept),
      .prod(s1_prod), .live(s1_live), .last(s1_last),
      .sum_q(s2_sum), .wr_q(s2_wr), .row_q(s2_row)
   );

   mipa_writeback #(.S(S), .P(P), .AW(AW), .RW(RW)) u_s3 (
      .clk(clk_i), .rst(rst_i), .load(accept), .init(cinit_i),
      .wr(s2_wr), .sum(s2_sum), .row(s2_row), .res(res_o)
   );
endmodule

// File: rtl/mipa_unit_chk.sv
module mipa_unit_chk #(
   parameter int unsigned S  = 8,
   parameter int unsigned P  = 4,
   parameter int unsigned AW = 40
) (
   input logic            clk,
   input logic            rst,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic [S*AW-1:0] res,
   input logic [P-1:0]    wr
);
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);

   assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> busy);

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |=> $stable(res));

   assert_no_idle_write_R7: assert property (@(posedge clk) disable iff (rst)
      (wr != '0) |-> busy);
endmodule

bind mipa_unit mipa_unit_chk #(.S(S), .P(P), .AW(AW)) chk_i (
   .clk(clk_i), .rst(rst_i), .start(start_i), .busy(busy_o),
   .done(done_o), .res(res_o), .wr(s2_wr)
);

// File: tb/mipa_unit_tb.sv
module mipa_unit_tb_top;
   localparam int S  = 8;
   localparam int P  = 4;
   localparam int VW = 16;
   localparam int AW = 40;
   localparam int PW = 3;
   localparam int CW = 4;

   logic            clk = 1'b0;
   logic            rst;
   logic            start;
   logic [CW-1:0]   cnt;
   logic [S*VW-1:0] val;
   logic [S*PW-1:0] pos;
   logic [S-1:0]    eor;
   logic [S*VW-1:0] vec;
   logic [S*AW-1:0] cinit;
   logic            busy;
   logic            done;
   logic [S*AW-1:0] res;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always #2.5 clk = ~clk;

   mipa_unit dut_i (
      .clk_i(clk), .rst_i(rst), .start_i(start), .cnt_i(cnt), .val_i(val),
      .pos_i(pos), .eor_i(eor), .vec_i(vec), .cinit_i(cinit),
      .busy_o(busy), .done_o(done), .res_o(res)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // expected result entries from the requirements
   function automatic logic [S*AW-1:0] model(input int n);
      logic [S*AW-1:0] e;
      logic signed [AW-1:0] acc;
      logic signed [AW-1:0] a;
      logic signed [AW-1:0] b;
      int row;
      e   = cinit;
      acc = '0;
      row = 0;
      for (int i = 0; i < n; i++) begin
         a   = AW'($signed(val[i*VW +: VW]));
         b   = AW'($signed(vec[pos[i*PW +: PW]*VW +: VW]));
         acc = acc + a * b;
         if (eor[i] || i == n - 1) begin
            e[row*AW +: AW] = e[row*AW +: AW] + acc;
            row = row + 1;
            acc = '0;
         end
      end
      return e;
   endfunction

   // run one operation; restart=1 also pulses start mid-operation with garbage cinit
   task automatic run_case(input int n, input string tag, input bit restart);
      logic [S*AW-1:0] exp;
      logic [S*AW-1:0] keep;
      int k;
      int lat;
      exp  = model(n);
      keep = cinit;
      cnt  = CW'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      k = 0;
      do begin
         if (restart && k == 1) begin
            cinit = ~keep;
            cnt   = CW'(S);
            start = 1'b1;
         end
         @(negedge clk);
         start = 1'b0;
         cinit = keep;
         cnt   = CW'(n);
         k++;
      end while (!done && k < 64);
      lat = (n == 0) ? 1 : (n + P - 1) / P + 3;
      check({tag, " done latency R8"}, AW'(k), AW'(lat));
      check({tag, " busy low at done R8"}, AW'(busy), '0);
      for (int j = 0; j < S; j++) check(tag, res[j*AW +: AW], exp[j*AW +: AW]);
      @(negedge clk);
   endtask

   task automatic rand_data();
      for (int i = 0; i < S; i++) begin
         val[i*VW +: VW]   = VW'($urandom);
         vec[i*VW +: VW]   = VW'($urandom);
         pos[i*PW +: PW]   = PW'($urandom);
         cinit[i*AW +: AW] = AW'({$urandom, $urandom});
      end
   endtask

   initial begin
      rst = 1'b1; start = 1'b0; cnt = '0; val = '0; pos = '0; eor = '0; vec = '0; cinit = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check("R1 busy", AW'(busy), '0);
      check("R1 done", AW'(done), '0);
      for (int j = 0; j < S; j++) check("R1 result entry", res[j*AW +: AW], '0);

      // R4: every element closes its own row, P writes per cycle
      rand_data(); eor = '1;
      run_case(8, "R4 row per element", 1'b0);

      // R5: one row spanning both lane groups
      rand_data(); eor = 8'b1000_0000;
      run_case(8, "R5 carried row", 1'b0);

      // R7: markers and values beyond the count ignored, upper entries kept
      rand_data(); eor = 8'b1100_0010;
      run_case(6, "R7 lanes past count", 1'b0);

      // R6: last element without marker is forced closed
      rand_data(); eor = 8'b0000_0100;
      run_case(5, "R6 forced close", 1'b0);

      // R9: zero count
      rand_data(); eor = 8'b0101_0101;
      run_case(0, "R9 empty section", 1'b0);

      // R3: extreme negatives and 40-bit wrap
      rand_data();
      for (int i = 0; i < S; i++) begin
         val[i*VW +: VW] = 16'h8000;
         vec[i*VW +: VW] = 16'h8000;
      end
      cinit[0 +: AW] = 40'h7F_FFFF_FFFF;
      eor = 8'b1000_0000;
      run_case(8, "R3 wrap and sign", 1'b0);

      // R2: start while busy ignored
      rand_data(); eor = 8'b0010_0100;
      run_case(7, "R2 busy start ignored", 1'b1);

      // R3/R4/R5/R6: every marker pattern for every count
      for (int n = 1; n <= S; n++) begin
         for (int pat = 0; pat < (1 << n); pat++) begin
            rand_data();
            eor = S'(pat) | (S'($urandom) & ~((S'(1) << n) - S'(1)));
            run_case(n, "R3 sweep", 1'b0);
         end
      end

      // R10: idle outputs hold
      begin
         logic [S*AW-1:0] snap;
         snap = res;
         cinit = ~cinit;
         repeat (5) @(negedge clk);
         for (int j = 0; j < S; j++) check("R10 idle hold", res[j*AW +: AW], snap[j*AW +: AW]);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule